// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision stage of an 8-input interrupt controller. It takes the current request, mask and in-service vectors, plus a rotation base. It reports whether the CPU should be interrupted and which input pin should be served. Priorities are relative to the rotation base. The pin equal to the base has the highest priority, and the ranking continues upward from it, wrapping past the top pin back to pin 0.

An interrupt is raised only when the best unmasked request strictly outranks the best in-service level. Lower in-service bits never matter. On an instance built as the cascade master, a nested-mode control can take the cascade pin out of the in-service comparison. A slave device behind that pin can then interrupt again while the pin is still in service. The block is purely combinational. Latching requests and decoding commands are done elsewhere.

Top module: `prio_resolver`

## Requirements
- R1: With no request that is both set in `req_vec` and clear in `mask_vec`, `irq_valid` is 0 and `irq_pin` reads 0.
- R2: A request bit whose mask bit is 1 has no effect on `irq_valid` or `irq_pin`.
- R3: Pin n has relative priority (n − `rot_base`) mod 8, where 0 is the highest. Among pending requests, the one with the smallest relative priority wins.
- R4: With `isr_vec` all zero, any pending request sets `irq_valid` to 1, and `irq_pin` gives the winning pin.
- R5: When the winning request's relative priority is equal to or lower than that of the highest in-service bit, `irq_valid` is 0.
- R6: When the winning request's relative priority is strictly higher than that of every effective in-service bit, `irq_valid` is 1 and `irq_pin` = (winning relative priority + `rot_base`) mod 8.
- R7: In-service bits ranking below the highest in-service bit have no effect on the result.
- R8: On a master instance with `nest_special` = 1, in-service bit 2 (the cascade pin) is ignored when the in-service level is computed.
- R9: With `nest_special` = 0, or on a slave instance, in-service bit 2 takes part in the comparison like any other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_vec | input | 8 | Latched request bits, one per pin |
| mask_vec | input | 8 | Mask bits; 1 blocks the pin's request |
| isr_vec | input | 8 | In-service bits, one per pin |
| rot_base | input | 3 | Pin holding relative priority 0 |
| nest_special | input | 1 | Excludes the cascade pin from the in-service level (master only) |
| irq_valid | output | 1 | Interrupt should be raised to the CPU |
| irq_pin | output | 3 | Pin to be served; 0 when irq_valid is 0 |

## Verification
The bench builds two copies from the same inputs. One uses the default parameters (8 pins, master role, cascade on pin 2). The other is identical except that it is a slave. The pair makes the nested-mode difference visible: the same in-service bit 2 blocks a request on one copy and not on the other. The sweep covers all eight rotation bases on both copies, so the wrap of the relative ranking past pin 7 is exercised at every base.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;
   // Sentinel convention: a search over an empty vector returns the vector width.
   function automatic int unsigned idx_bits(input int unsigned width);
      return (width <= 1) ? 1 : $clog2(width);
   endfunction
endpackage

// File: rtl/prio_rot_align.sv
// Re-indexes a vector so that bit p of the result is the pin whose
// relative priority is p under the given rotation base.
module prio_rot_align #(
   parameter int WIDTH = 8,
   localparam int IW = prio_res_pkg::idx_bits(WIDTH)
) (
   input  logic [WIDTH-1:0] vec,
   input  logic [IW-1:0]    base,
   output logic [WIDTH-1:0] rel
);
   for (genvar p = 0; p < WIDTH; p++) begin : g_slot
      assign rel[p] = vec[IW'(p) + base];
   end
endmodule

// File: rtl/prio_first_set.sv
// Returns the index of the lowest set bit, or WIDTH when none is set.
module prio_first_set #(
   parameter int WIDTH = 8,
   localparam int IW = prio_res_pkg::idx_bits(WIDTH)
) (
   input  logic [WIDTH-1:0] vec,
   output logic [IW:0]      prio
);
   always_comb begin
      prio = (IW+1)'(WIDTH);
      for (int i = WIDTH-1; i >= 0; i--) begin
         if (vec[i]) prio = (IW+1)'(i);
      end
   end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver #(
   parameter int WIDTH       = 8,
   parameter bit IS_MASTER   = 1'b1,
   parameter int CASCADE_PIN = 2,
   localparam int IW = prio_res_pkg::idx_bits(WIDTH)
) (
   input  logic [WIDTH-1:0] req_vec,
   input  logic [WIDTH-1:0] mask_vec,
   input  logic [WIDTH-1:0] isr_vec,
   input  logic [IW-1:0]    rot_base,
   input  logic             nest_special,
   output logic             irq_valid,
   output logic [IW-1:0]    irq_pin
);
   // Elaboration-time parameter checks
   if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("prio_resolver: WIDTH must be a power of two of at least 2");
   end
   if (CASCADE_PIN < 0 || CASCADE_PIN >= WIDTH) begin : g_bad_cascade
      $error("prio_resolver: CASCADE_PIN out of range");
   end

   logic [WIDTH-1:0] pend_vec, isr_eff;
   logic [WIDTH-1:0] pend_rel, isr_rel;
   logic [IW:0]      pend_prio, isr_prio;
   logic             hit;

   assign pend_vec = req_vec & ~mask_vec;

   // Variant choice: only a master may drop the cascade pin from the in-service level.
   if (IS_MASTER) begin : g_master
      logic [WIDTH-1:0] casc_bit;
      assign casc_bit = {{(WIDTH-1){1'b0}}, nest_special} << CASCADE_PIN;
      assign isr_eff  = isr_vec & ~casc_bit;
   end else begin : g_slave
      logic nest_unused;
      assign nest_unused = nest_special;
      assign isr_eff     = isr_vec;
   end

   prio_rot_align #(.WIDTH(WIDTH)) u_align_pend (
      .vec(pend_vec), .base(rot_base), .rel(pend_rel));
   prio_rot_align #(.WIDTH(WIDTH)) u_align_isr (
      .vec(isr_eff),  .base(rot_base), .rel(isr_rel));

   prio_first_set #(.WIDTH(WIDTH)) u_find_pend (.vec(pend_rel), .prio(pend_prio));
   prio_first_set #(.WIDTH(WIDTH)) u_find_isr  (.vec(isr_rel),  .prio(isr_prio));

   // isr_prio never exceeds WIDTH, so "none pending" (== WIDTH) can never win.
   assign hit       = (pend_prio < isr_prio);
   assign irq_valid = hit;
   assign irq_pin   = hit ? (pend_prio[IW-1:0] + rot_base) : '0;
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
   parameter int WIDTH       = 8,
   parameter bit IS_MASTER   = 1'b1,
   parameter int CASCADE_PIN = 2,
   localparam int IW = prio_res_pkg::idx_bits(WIDTH)
) (
   input logic [WIDTH-1:0] req_vec,
   input logic [WIDTH-1:0] mask_vec,
   input logic [WIDTH-1:0] isr_vec,
   input logic [IW-1:0]    rot_base,
   input logic             nest_special,
   input logic             irq_valid,
   input logic [IW-1:0]    irq_pin
);
   function automatic logic [IW-1:0] relpos(input logic [IW-1:0] pin, input logic [IW-1:0] base);
      return pin - base;
   endfunction

   logic known;
   logic beaten_by_pend;
   logic blocked_by_isr;

   assign known = !$isunknown({req_vec, mask_vec, isr_vec, rot_base, nest_special, irq_valid, irq_pin});

   always_comb begin
      beaten_by_pend = 1'b0;
      blocked_by_isr = 1'b0;
      for (int i = 0; i < WIDTH; i++) begin
         if (req_vec[i] && !mask_vec[i] && relpos(IW'(i), rot_base) < relpos(irq_pin, rot_base))
            beaten_by_pend = 1'b1;
         if (isr_vec[i] && !(IS_MASTER && nest_special && i == CASCADE_PIN) &&
             relpos(IW'(i), rot_base) <= relpos(irq_pin, rot_base))
            blocked_by_isr = 1'b1;
      end
   end

   always_comb begin
      if (known) begin
         p_idle_when_none_r1: assert (!((req_vec & ~mask_vec) == '0 && (irq_valid || irq_pin != '0)));
         p_pin_is_pending_r2: assert (!irq_valid || (req_vec[irq_pin] && !mask_vec[irq_pin]));
         p_best_pending_r3:   assert (!irq_valid || !beaten_by_pend);
         p_free_isr_raise_r4: assert (!(isr_vec == '0 && (req_vec & ~mask_vec) != '0) || irq_valid);
         p_strict_beat_r5:    assert (!irq_valid || !blocked_by_isr);
      end
   end
endmodule

bind prio_resolver prio_resolver_chk #(
   .WIDTH(WIDTH), .IS_MASTER(IS_MASTER), .CASCADE_PIN(CASCADE_PIN)
) u_chk (
   .req_vec(req_vec), .mask_vec(mask_vec), .isr_vec(isr_vec), .rot_base(rot_base),
   .nest_special(nest_special), .irq_valid(irq_valid), .irq_pin(irq_pin)
);

// File: tb/sim_prio_resolver.sv
module sim_prio_resolver;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] req = '0, msk = '0, isr = '0;
   logic [2:0] rot = '0;
   logic       sf  = 1'b0;
   logic       v0, v1;
   logic [2:0] p0, p1;
   int         total = 0, bad = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   prio_resolver u0 (
      .req_vec(req), .mask_vec(msk), .isr_vec(isr), .rot_base(rot),
      .nest_special(sf), .irq_valid(v0), .irq_pin(p0));

   prio_resolver #(.IS_MASTER(1'b0)) u1 (
      .req_vec(req), .mask_vec(msk), .isr_vec(isr), .rot_base(rot),
      .nest_special(sf), .irq_valid(v1), .irq_pin(p1));

   typedef struct packed {
      logic [7:0] req, msk, isr;
      logic [2:0] rot;
      logic       sf;
      logic       v;
      logic [2:0] pin;
      logic [3:0] tag;
   } vec_t;

   // req, mask, isr, rot, nest, exp_valid, exp_pin, requirement
   localparam int NV = 15;
   localparam vec_t TBL [NV] = '{
      '{8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 3'd0, 4'd1},  // R1 nothing
      '{8'h10, 8'h10, 8'h00, 3'd0, 1'b0, 1'b0, 3'd0, 4'd2},  // R2 masked only
      '{8'h30, 8'h10, 8'h00, 3'd0, 1'b0, 1'b1, 3'd5, 4'd2},  // R2 masked pin skipped
      '{8'h81, 8'h00, 8'h00, 3'd0, 1'b0, 1'b1, 3'd0, 4'd3},  // R3 base 0
      '{8'h81, 8'h00, 8'h00, 3'd1, 1'b0, 1'b1, 3'd7, 4'd3},  // R3 wrap
      '{8'h0C, 8'h00, 8'h00, 3'd3, 1'b0, 1'b1, 3'd3, 4'd3},  // R3 base 3
      '{8'h80, 8'h00, 8'h00, 3'd0, 1'b0, 1'b1, 3'd7, 4'd4},  // R4 lowest pin raises
      '{8'h08, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0, 3'd0, 4'd5},  // R5 equal level
      '{8'h08, 8'h00, 8'h02, 3'd0, 1'b0, 1'b0, 3'd0, 4'd5},  // R5 lower than isr
      '{8'h04, 8'h00, 8'h88, 3'd4, 1'b0, 1'b0, 3'd0, 4'd5},  // R5 rotated
      '{8'h02, 8'h00, 8'h08, 3'd0, 1'b0, 1'b1, 3'd1, 4'd6},  // R6 beats isr
      '{8'h10, 8'h00, 8'hA0, 3'd0, 1'b0, 1'b1, 3'd4, 4'd7},  // R7 lower isr bit 7 ignored
      '{8'h04, 8'h00, 8'h04, 3'd0, 1'b1, 1'b1, 3'd2, 4'd8},  // R8 cascade re-entry
      '{8'h08, 8'h00, 8'h04, 3'd0, 1'b1, 1'b1, 3'd3, 4'd8},  // R8 lower pin passes
      '{8'h04, 8'h00, 8'h04, 3'd0, 1'b0, 1'b0, 3'd0, 4'd9}   // R9 nest off blocks
   };

   // Reference loop model written from the requirements.
   function automatic logic [3:0] ref_model(input logic [7:0] rq, input logic [7:0] mk,
                                            input logic [7:0] is, input logic [2:0] rb,
                                            input logic nest, input bit master);
      int pp = 8, ip = 8;
      for (int p = 7; p >= 0; p--) begin
         int pin = (p + rb) % 8;
         if (rq[pin] && !mk[pin]) pp = p;
         if (is[pin] && !(master && nest && pin == 2)) ip = p;
      end
      if (pp < ip) return {1'b1, 3'((pp + rb) % 8)};
      return 4'b0000;
   endfunction

   task automatic check(input string tag, input logic av, input logic [2:0] ap,
                        input logic ev, input logic [2:0] ep);
      total++;
      if (av !== ev || ap !== ep) begin
         bad++;
         $display("FAIL %s: got valid=%0b pin=%0d expected valid=%0b pin=%0d (req=%h mask=%h isr=%h rot=%0d nest=%0b)",
                  tag, av, ap, ev, ep, req, msk, isr, rot, sf);
      end
   endtask

   task automatic apply(input logic [7:0] rq, input logic [7:0] mk, input logic [7:0] is,
                        input logic [2:0] rb, input logic nest);
      @(negedge clk);
      req = rq; msk = mk; isr = is; rot = rb; sf = nest;
      #5;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [3:0] e;
      // Reset state: all inputs idle gives no interrupt (R1)
      repeat (3) @(posedge clk);
      #5;
      check("R1 reset", v0, p0, 1'b0, 3'd0);
      check("R1 reset slave", v1, p1, 1'b0, 3'd0);
      rst = 1'b0;

      // Table walk on the master instance
      for (int k = 0; k < NV; k++) begin
         apply(TBL[k].req, TBL[k].msk, TBL[k].isr, TBL[k].rot, TBL[k].sf);
         check($sformatf("R%0d vector %0d", TBL[k].tag, k), v0, p0, TBL[k].v, TBL[k].pin);
      end

      // Directed: a slave ignores the nested control (R9)
      apply(8'h04, 8'h00, 8'h04, 3'd0, 1'b1);
      check("R9 slave keeps cascade bit", v1, p1, 1'b0, 3'd0);
      // Directed: master nest on, higher isr bit still blocks (R8)
      apply(8'h08, 8'h00, 8'h05, 3'd0, 1'b1);
      check("R8 other isr bits still count", v0, p0, 1'b0, 3'd0);
      // Directed: all masked, all requested (R2)
      apply(8'hFF, 8'hFF, 8'h00, 3'd5, 1'b0);
      check("R2 all masked", v0, p0, 1'b0, 3'd0);
      // Directed: full requests, each base selects itself (R3, R4)
      for (int b = 0; b < 8; b++) begin
         apply(8'hFF, 8'h00, 8'h00, 3'(b), 1'b0);
         check("R3 full request follows base", v0, p0, 1'b1, 3'(b));
      end

      // Random sweep of every rotation base against the reference (R3 R5 R6 R7 R8 R9)
      for (int b = 0; b < 8; b++) begin
         for (int n = 0; n < 150; n++) begin
            apply(8'($urandom()), 8'($urandom()) & 8'($urandom()), 8'($urandom()) & 8'($urandom()),
                  3'(b), 1'($urandom()));
            e = ref_model(req, msk, isr, rot, sf, 1'b1);
            check("R6 sweep master", v0, p0, e[3], e[2:0]);
            e = ref_model(req, msk, isr, rot, sf, 1'b0);
            check("R9 sweep slave", v1, p1, e[3], e[2:0]);
         end
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule